// File: doc/BRIEF.md
# Rollover-Aligned Serial Byte Transmitter

This block sends 8-bit bytes over one asynchronous serial line. A host register interface hands it a byte with a one-cycle write strobe. The block does not start the frame at once. It waits for the next wrap of an internal divide-by-16 counter and drives the start bit from that point. The counter runs freely on a 16x-baud tick that a separate rate generator supplies. Every later bit edge of the frame also falls on a wrap of that counter, so the phase of the write inside a bit period never shows on the line.

A frame has a low start bit, then eight data bits sent least significant bit first, then a high stop bit. When the stop bit reaches the line, the block raises a sticky done flag. The flag stays up until the host pulses a clear input. A busy output covers the time from the accepted write until the stop bit ends. Writes that arrive during that time are dropped.

Top module: `bitclk_uart_tx`

## Requirements
- R1: While reset is held, and after it until the first accepted write, `txd` is 1, `busy` is 0 and `done` is 0. A reset in the middle of a frame ends the frame and returns the line to 1.
- R2: A write accepted at clock edge E only arms the block. `txd` goes to 0 (start bit) on the edge of the first counter wrap after E. A wrap at edge E itself does not count. A wrap is an edge at which `baud_tick` is 1 while the internal count of ticks since reset, modulo 16, is at 15.
- R3: Each bit occupies exactly 16 `baud_tick` pulses, and every change of `txd` during a frame happens on a wrap edge, whatever the tick phase at the write.
- R4: The line carries 0 (start), then `wr_data[0]` through `wr_data[7]` in that order, then 1 (stop). After the stop bit it stays at 1.
- R5: `done` rises on the same edge that `txd` starts the stop bit.
- R6: `done` stays 1 until a cycle with `clr_done` high, and then reads 0 from the next edge. If `clr_done` is high on the edge where the stop bit starts, `done` is still 1 afterwards.
- R7: `busy` is 1 from the edge after an accepted write until the wrap edge that ends the stop bit, and 0 otherwise.
- R8: A write while `busy` is 1 is ignored. The frame in progress keeps its data and timing, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_stb | input | 1 | Write strobe for the data byte |
| wr_data | input | 8 | Byte to send |
| clr_done | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line output |
| busy | output | 1 | A frame is armed or being sent |
| done | output | 1 | Sticky flag, set when the stop bit begins |

## Verification
Every result is a registered output, so it shows up on the edge of the event that causes it. `busy` changes on the write edge. The start bit, each data bit and the stop bit each appear on the wrap edge of their slot, and `done` rises on the stop-bit wrap edge. The bench counts the ticks it sends and works out the wrap at which each frame must start. From that it computes the expected line value, busy and flag for each cycle. It compares all three outputs at every falling clock edge, half a period after the edge that may change them. The sweep places the write at each of the 16 tick phases, both on a tick edge and between ticks, so the case of a write on a wrap edge is covered.

// File: rtl/bitclk_uart_pkg.sv
package bitclk_uart_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SEND  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/bitclk_rst_sync.sv
module bitclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bitclk_div16.sv
module bitclk_div16 #(
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = $clog2(OVERSAMPLE)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic roll_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = tick_i;
  assign roll_o = tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (cnt_q == CNT_LAST) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: a wrap always restarts the bit slot at count zero
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |=> (cnt_q == '0));

  // R3: without a tick the counter holds its value
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/bitclk_frame_seq.sv
module bitclk_frame_seq
  import bitclk_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = DATA_W + 2,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              stop_start_o
);
  localparam logic [IDX_W-1:0] LAST_DATA_IDX = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] STOP_IDX      = IDX_W'(DATA_W + 1);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              stop_start;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    txd_d      = txd_q;
    stop_start = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        txd_d = 1'b1;
        if (wr_i) begin
          sh_d    = data_i;
          state_d = TX_ARMED;
        end
      end
      TX_ARMED: begin
        if (roll_i) begin
          state_d = TX_SEND;
          idx_d   = '0;
          txd_d   = 1'b0;
        end
      end
      TX_SEND: begin
        if (roll_i) begin
          if (idx_q == STOP_IDX) begin
            state_d = TX_IDLE;
            idx_d   = '0;
            txd_d   = 1'b1;
          end else if (idx_q == LAST_DATA_IDX) begin
            idx_d      = idx_q + 1'b1;
            txd_d      = 1'b1;
            stop_start = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
            txd_d = sh_q[0];
            sh_d  = {1'b0, sh_q[DATA_W-1:1]};
          end
        end
      end
      default: begin
        state_d = TX_IDLE;
        txd_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      txd_q   <= txd_d;
    end
  end

  assign txd_o        = txd_q;
  assign busy_o       = (state_q != TX_IDLE);
  assign stop_start_o = stop_start;

  // R3: the line only moves on a counter wrap
  p_edge_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_q != $past(txd_q)) |-> $past(roll_i));

  // R2: the wrap seen while armed opens the start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_ARMED && roll_i) |=> (!txd_q && state_q == TX_SEND));

  // R8: a write during a bit slot leaves the shift data untouched
  p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SEND && wr_i && !roll_i) |=> $stable(sh_q));

  // R4: the stop bit drives a high level
  p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_start |=> txd_q);
endmodule

// File: rtl/bitclk_done_flag.sv
module bitclk_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R5: the stop-bit event raises the flag
  p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R6: the flag stays up without a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R6: a clear with no set drops the flag
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/bitclk_uart_tx.sv
module bitclk_uart_tx #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_done,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  logic rst_int_n;
  logic roll;
  logic stop_start;

  bitclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bitclk_div16 #(.OVERSAMPLE(OVERSAMPLE)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (baud_tick),
    .roll_o (roll)
  );

  bitclk_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .roll_i       (roll),
    .wr_i         (wr_stb),
    .data_i       (wr_data),
    .txd_o        (txd),
    .busy_o       (busy),
    .stop_start_o (stop_start)
  );

  bitclk_done_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (stop_start),
    .clr_i  (clr_done),
    .flag_o (done)
  );

  // R1: an idle block holds the line high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> txd);

  // R7: a write to an idle block turns busy on at the next edge
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && wr_stb) |=> busy);
endmodule

// File: tb/bitclk_uart_tx_tb_top.sv
module bitclk_uart_tx_tb_top;
  localparam int TICK_GAP = 3;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_done = 1'b0;
  logic       txd, busy, done;

  bitclk_uart_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .clr_done(clr_done), .txd(txd), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  // bench model state
  int         n_ticks = 0;
  bit         have = 1'b0;
  int         r_start = 0;
  logic [7:0] m_data = 8'h00;
  bit         m_flag = 1'b0;
  bit         ticks_en = 1'b0;
  bit         collide = 1'b0;
  int         gap_cnt = 0;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;
  bit         finished = 1'b0;
  string      sect = "R1 reset";

  // model update on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      n_ticks = 0; have = 1'b0; m_flag = 1'b0;
    end else begin
      int n_old;
      bit set_ev;
      n_old = n_ticks;
      if (baud_tick) n_ticks++;
      set_ev = baud_tick && have && (n_ticks == r_start + 144);
      if (set_ev)        m_flag = 1'b1;
      else if (clr_done) m_flag = 1'b0;
      if (wr_stb && (!have || n_old >= r_start + 160)) begin
        have = 1'b1;
        r_start = 16 * (n_ticks / 16 + 1);
        m_data = wr_data;
      end
    end
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at ticks %0d", tag, act, exp, n_ticks);
    end
  endtask

  // compare at the falling edge, then drive tick and collision clear
  always @(negedge clk) begin
    logic e_txd, e_busy;
    string ftag;
    int b;
    e_txd = 1'b1; e_busy = 1'b0; ftag = "R1";
    if (have) begin
      e_busy = (n_ticks < r_start + 160);  // R7
      if (n_ticks < r_start) begin
        ftag = "R2";
      end else begin
        b = (n_ticks - r_start) / 16;
        if (b == 0)      begin e_txd = 1'b0;            ftag = "R2"; end
        else if (b <= 8) begin e_txd = m_data[b-1];     ftag = "R4"; end
        else             begin e_txd = 1'b1;            ftag = "R4"; end
      end
    end
    if (!finished) begin
      check1({sect, " txd ", ftag}, txd, e_txd);
      check1({sect, " busy R7"}, busy, e_busy);
      check1({sect, " done R5/R6"}, done, m_flag);
    end
    if (ticks_en) begin
      baud_tick = (gap_cnt == 0);
      gap_cnt = (gap_cnt == TICK_GAP - 1) ? 0 : gap_cnt + 1;
    end else begin
      baud_tick = 1'b0;
      gap_cnt = 0;
    end
    // R6: clear on the very edge where the stop bit starts
    clr_done = collide && baud_tick && have && (n_ticks + 1 == r_start + 144);
  end

  task automatic wait_idle();
    while (have && n_ticks < r_start + 164) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // place a write at a chosen tick phase, either on a tick edge or between ticks
  task automatic send(input int ph, input bit on_tick, input logic [7:0] d);
    forever begin
      @(negedge clk); #1;
      if (on_tick ? (baud_tick && ((n_ticks + 1) % 16 == ph))
                  : (!baud_tick && (n_ticks % 16 == ph))) break;
    end
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); #1;
    clr_done = 1'b1;
    @(negedge clk); #1;
    clr_done = 1'b0;
  endtask

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    // R1: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ticks_en = 1'b1;
    repeat (20) @(negedge clk);

    // R3: write at each of the 16 tick phases, on a tick edge (phase 0 is a wrap)
    sect = "R3 phase sweep";
    for (int ph = 0; ph < 16; ph++) begin
      send(ph, 1'b1, 8'((ph * 37) ^ 8'h3C));
      wait_idle();
      pulse_clear();  // R6 plain clear
    end
    // R3: writes that land between ticks
    for (int ph = 0; ph < 16; ph += 5) begin
      send(ph, 1'b0, 8'(8'hC3 + ph));
      wait_idle();
    end
    // R4: fixed data patterns, flag left standing between frames (R6 sticky)
    sect = "R4 patterns";
    for (int i = 0; i < 6; i++) begin
      send(i * 3, 1'b1, pats[i]);
      wait_idle();
    end
    pulse_clear();

    // R8: writes while armed and mid-frame are dropped
    sect = "R8 write while busy";
    send(7, 1'b1, 8'h96);
    @(negedge clk); #1; wr_stb = 1'b1; wr_data = 8'h0F;
    @(negedge clk); #1; wr_stb = 1'b0;
    while (n_ticks < r_start + 70) @(negedge clk);
    #1; wr_stb = 1'b1; wr_data = 8'hF0;
    @(negedge clk); #1; wr_stb = 1'b0;
    while (n_ticks < r_start + 159) @(negedge clk);
    #1; wr_stb = 1'b1; wr_data = 8'h33;  // lands on or near the closing wrap
    @(negedge clk); #1; wr_stb = 1'b0;
    wait_idle();
    pulse_clear();

    // R6: clear collides with the set edge
    sect = "R6 set wins";
    collide = 1'b1;
    send(11, 1'b1, 8'h6D);
    wait_idle();
    collide = 1'b0;
    pulse_clear();

    // R1: reset in the middle of a frame
    sect = "R1 mid reset";
    send(2, 1'b1, 8'h55);
    while (n_ticks < r_start + 60) @(negedge clk);
    #1; rst_n = 1'b0; ticks_en = 1'b0;
    repeat (3) @(negedge clk);
    #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ticks_en = 1'b1;
    send(9, 1'b1, 8'hB2);
    wait_idle();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule